// File: doc/BRIEF.md
# Rotate Unit with Carry and Overflow Flags

This block is a purely combinational rotator for an integer execution path. It rotates an operand of 8 or 16 bits by a count held in an 8-bit field. It supports four operations: a plain left rotate, a plain right rotate, and a rotate in each direction that runs through the carry flag. For each operation it returns the rotated result, the new carry flag (CF) and the new overflow flag (OF). It also returns one write strobe for each of the two flags, which tells the surrounding flag register whether to take the new value.

The plain rotates and the through-carry rotates reduce the count in different ways. They also differ in when they leave the flags alone and in how OF is formed. The sign, zero, auxiliary-carry and parity flags are not produced here, so a rotate never changes them. Decoding, operand fetch and flag storage belong to the caller.

Top module: `rot_unit`

## Requirements
- R1: The `op_sel` encoding is 00 for plain left, 01 for plain right, 10 for left through carry and 11 for right through carry. A plain rotate moves the operand by `count & (WIDTH-1)` positions, with bits leaving one end entering the other.
- R2: A through-carry rotate moves the (WIDTH+1)-bit ring formed by `cf_in` above the operand by `count % (WIDTH+1)` positions. That is modulo 9 for 8 bits and modulo 17 for 16 bits. `cf_out` is the ring's top bit afterwards and `result` is its lower WIDTH bits.
- R3: For a plain rotate with `count` equal to 0, `result` equals the operand and both `cf_we` and `of_we` are 0. `cf_out` equals `cf_in` and `of_out` equals `of_in`.
- R4: For a plain rotate whose nonzero `count` masks to zero (for example 8 or 16 at WIDTH 8), `result` equals the operand and both write strobes are 1. The flags follow R5 or R6.
- R5: After a plain left rotate with a nonzero count, `cf_out` is `result[0]` and `of_out` is `result[WIDTH-1] ^ result[0]`.
- R6: After a plain right rotate with a nonzero count, `cf_out` is `result[WIDTH-1]` and `of_out` is `result[WIDTH-1] ^ result[WIDTH-2]`.
- R7: After a left rotate through carry, `of_out` is `result[WIDTH-1] ^ cf_out`.
- R8: After a right rotate through carry, `of_out` is the operand's MSB XOR `cf_in`, taken before rotating.
- R9: A through-carry rotate always asserts both write strobes. When its reduced count is 0, `result` equals the operand and `cf_out` equals `cf_in`.
- R10: `cf_we` and `of_we` are always equal. When they are low, the outputs carry the incoming flag values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | WIDTH | Value to rotate |
| count | input | 8 | Raw rotate count |
| op_sel | input | 2 | Operation select (see R1) |
| cf_in | input | 1 | Current carry flag |
| of_in | input | 1 | Current overflow flag |
| result | output | WIDTH | Rotated value |
| cf_out | output | 1 | Carry flag to write |
| of_out | output | 1 | Overflow flag to write |
| cf_we | output | 1 | Carry flag write strobe |
| of_we | output | 1 | Overflow flag write strobe |

## Verification
Assertions check these on every input pattern:
- flag suppression and the operand pass-through on a zero plain count;
- the carry and overflow relations to the result for the left rotates and the plain right rotate;
- the carry hold on a zero through-carry reduction;
- the pairing of the strobes.

Only the bench's scenarios can show that the bit movement itself is right. The bench compares every operation over all 256 counts, with several operands and flag inputs, against a one-bit-at-a-time reference loop. The same scenarios cover the masked-to-zero plain counts and the pre-rotation OF of the right rotate through carry.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [1:0] {
    ROT_L = 2'b00,
    ROT_R = 2'b01,
    RTC_L = 2'b10,
    RTC_R = 2'b11
  } rot_op_e;
endpackage

// File: rtl/rot_count_reduce.sv
module rot_count_reduce #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 8,
  localparam int EW   = $clog2(WIDTH + 1),
  localparam int LW   = $clog2(WIDTH)
) (
  input  logic [CNT_W-1:0] count,
  input  logic             thru,
  output logic [EW-1:0]    eff,
  output logic             raw_zero
);
  logic [EW-1:0] eff_mask;
  logic [EW-1:0] eff_mod;

  always_comb begin
    eff_mask = EW'(count[LW-1:0]);
    eff_mod  = EW'(count % CNT_W'(WIDTH + 1));
    eff      = thru ? eff_mod : eff_mask;
    raw_zero = (count == '0);
  end
endmodule

// File: rtl/rot_datapath.sv
module rot_datapath
  import rot_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int EW   = $clog2(WIDTH + 1),
  localparam int RW   = WIDTH + 1
) (
  input  rot_op_e          op,
  input  logic [WIDTH-1:0] operand,
  input  logic             cf_in,
  input  logic [EW-1:0]    eff,
  output logic [WIDTH-1:0] result,
  output logic             ring_cf
);
  logic [2*WIDTH-1:0] pl_l, pl_r;
  logic [RW-1:0]      ring;
  logic [2*RW-1:0]    rc_l, rc_r;

  always_comb begin
    pl_l = {operand, operand} << eff;
    pl_r = {operand, operand} >> eff;
    ring = {cf_in, operand};
    rc_l = {ring, ring} << eff;
    rc_r = {ring, ring} >> eff;
    ring_cf = cf_in;
    unique case (op)
      ROT_L:   result = pl_l[2*WIDTH-1:WIDTH];
      ROT_R:   result = pl_r[WIDTH-1:0];
      RTC_L:   {ring_cf, result} = rc_l[2*RW-1:RW];
      default: {ring_cf, result} = rc_r[RW-1:0];
    endcase
  end
endmodule

// File: rtl/rot_flag_gen.sv
module rot_flag_gen
  import rot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  rot_op_e          op,
  input  logic [WIDTH-1:0] operand,
  input  logic [WIDTH-1:0] result,
  input  logic             ring_cf,
  input  logic             cf_in,
  input  logic             of_in,
  input  logic             raw_zero,
  output logic             cf_out,
  output logic             of_out,
  output logic             cf_we,
  output logic             of_we
);
  logic we, cf_new, of_new;

  always_comb begin
    we = op[1] | ~raw_zero;
    unique case (op)
      ROT_L: begin
        cf_new = result[0];
        of_new = result[WIDTH-1] ^ result[0];
      end
      ROT_R: begin
        cf_new = result[WIDTH-1];
        of_new = result[WIDTH-1] ^ result[WIDTH-2];
      end
      RTC_L: begin
        cf_new = ring_cf;
        of_new = result[WIDTH-1] ^ ring_cf;
      end
      default: begin
        cf_new = ring_cf;
        of_new = operand[WIDTH-1] ^ cf_in;
      end
    endcase
    cf_we  = we;
    of_we  = we;
    cf_out = we ? cf_new : cf_in;
    of_out = we ? of_new : of_in;
  end
endmodule

// File: rtl/rot_unit.sv
module rot_unit
  import rot_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int EW   = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] operand,
  input  logic [7:0]       count,
  input  logic [1:0]       op_sel,
  input  logic             cf_in,
  input  logic             of_in,
  output logic [WIDTH-1:0] result,
  output logic             cf_out,
  output logic             of_out,
  output logic             cf_we,
  output logic             of_we
);
  rot_op_e       op;
  logic [EW-1:0] eff;
  logic          raw_zero;
  logic          ring_cf;

  assign op = rot_op_e'(op_sel);

  rot_count_reduce #(.WIDTH(WIDTH), .CNT_W(8)) u_cnt (
    .count(count), .thru(op_sel[1]), .eff(eff), .raw_zero(raw_zero)
  );

  rot_datapath #(.WIDTH(WIDTH)) u_dp (
    .op(op), .operand(operand), .cf_in(cf_in), .eff(eff),
    .result(result), .ring_cf(ring_cf)
  );

  rot_flag_gen #(.WIDTH(WIDTH)) u_flg (
    .op(op), .operand(operand), .result(result), .ring_cf(ring_cf),
    .cf_in(cf_in), .of_in(of_in), .raw_zero(raw_zero),
    .cf_out(cf_out), .of_out(of_out), .cf_we(cf_we), .of_we(of_we)
  );

  always_comb begin
    if (op_sel[1] == 1'b0 && count == 8'd0) begin
      a_r3_zero_count_holds: assert (!cf_we && !of_we && result == operand
                                     && cf_out == cf_in && of_out == of_in);
    end
    if (op_sel == 2'b00 && count != 8'd0) begin
      a_r5_rol_flags: assert (cf_out == result[0]
                              && of_out == (result[WIDTH-1] ^ result[0]));
    end
    if (op_sel == 2'b01 && count != 8'd0) begin
      a_r6_ror_carry: assert (cf_out == result[WIDTH-1]);
    end
    if (op_sel == 2'b10) begin
      a_r7_rcl_overflow: assert (of_out == (result[WIDTH-1] ^ cf_out));
    end
    if (op_sel[1] && (count % (WIDTH + 1)) == 0) begin
      a_r9_ring_zero_holds: assert (result == operand && cf_out == cf_in
                                    && cf_we && of_we);
    end
    a_r10_strobes_paired: assert (cf_we == of_we);
  end
endmodule

// File: tb/sim_rot_unit.sv
module sim_rot_unit;
  localparam int W = 8;

  typedef struct packed {
    logic [W-1:0] res;
    logic         cf;
    logic         of;
    logic         we;
  } exp_t;

  logic clk;
  logic [W-1:0] operand;
  logic [7:0]   count;
  logic [1:0]   op_sel;
  logic         cf_in, of_in;
  logic [W-1:0] result;
  logic         cf_out, of_out, cf_we, of_we;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  rot_unit #(.WIDTH(W)) u0 (
    .operand(operand), .count(count), .op_sel(op_sel), .cf_in(cf_in),
    .of_in(of_in), .result(result), .cf_out(cf_out), .of_out(of_out),
    .cf_we(cf_we), .of_we(of_we)
  );

  function automatic exp_t model(input logic [1:0] op, input logic [W-1:0] d,
                                 input logic [7:0] c, input logic cfi,
                                 input logic ofi);
    exp_t e;
    int n;
    logic [W-1:0] v;
    logic cf, of0, t;
    v   = d;
    cf  = cfi;
    of0 = d[W-1] ^ cfi;
    if (op[1]) begin
      n = int'(c) % (W + 1);
      e.we = 1'b1;
    end else begin
      n = int'(c) % W;
      e.we = (c != 8'd0);
    end
    for (int i = 0; i < n; i++) begin
      case (op)
        2'b00: begin t = v[W-1]; v = {v[W-2:0], t}; end
        2'b01: begin t = v[0]; v = {t, v[W-1:1]}; end
        2'b10: begin t = v[W-1]; v = {v[W-2:0], cf}; cf = t; end
        default: begin t = v[0]; v = {cf, v[W-1:1]}; cf = t; end
      endcase
    end
    e.res = v;
    e.cf  = cfi;
    e.of  = ofi;
    if (e.we) begin
      case (op)
        2'b00: begin e.cf = v[0];   e.of = v[W-1] ^ v[0]; end
        2'b01: begin e.cf = v[W-1]; e.of = v[W-1] ^ v[W-2]; end
        2'b10: begin e.cf = cf;     e.of = v[W-1] ^ cf; end
        default: begin e.cf = cf;   e.of = of0; end
      endcase
    end
    return e;
  endfunction

  task automatic apply(input logic [1:0] op, input logic [W-1:0] d,
                       input logic [7:0] c, input logic cfi, input logic ofi);
    @(negedge clk);
    op_sel = op; operand = d; count = c; cf_in = cfi; of_in = ofi;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input exp_t e);
    n_chk++;
    if (result !== e.res || cf_out !== e.cf || of_out !== e.of ||
        cf_we !== e.we || of_we !== e.we) begin
      n_err++;
      $display("FAIL %s op=%0d cnt=%0d opnd=%h: got res=%h cf=%b of=%b we=%b/%b, exp res=%h cf=%b of=%b we=%b",
               tag, op_sel, count, operand, result, cf_out, of_out, cf_we,
               of_we, e.res, e.cf, e.of, e.we);
    end
  endtask

  task automatic t_idle_state;
    exp_t e;
    apply(2'b00, '0, 8'd0, 1'b0, 1'b0);
    e = '{res: '0, cf: 1'b0, of: 1'b0, we: 1'b0};
    check("R3 idle", e);
  endtask

  task automatic t_known_vectors;
    exp_t e;
    apply(2'b00, 8'h81, 8'd1, 1'b0, 1'b0);
    e = '{res: 8'h03, cf: 1'b1, of: 1'b1, we: 1'b1};
    check("R5 rol 81", e);
    apply(2'b01, 8'h01, 8'd1, 1'b0, 1'b0);
    e = '{res: 8'h80, cf: 1'b1, of: 1'b1, we: 1'b1};
    check("R6 ror 01", e);
    apply(2'b10, 8'h80, 8'd1, 1'b0, 1'b0);
    e = '{res: 8'h00, cf: 1'b1, of: 1'b1, we: 1'b1};
    check("R7 rcl 80", e);
    apply(2'b11, 8'h01, 8'd1, 1'b1, 1'b0);
    e = '{res: 8'h80, cf: 1'b1, of: 1'b1, we: 1'b1};
    check("R8 rcr 01", e);
  endtask

  task automatic t_raw_zero;
    exp_t e;
    for (int op = 0; op < 2; op++) begin
      apply(2'(op), 8'hA5, 8'd0, 1'b1, 1'b0);
      e = '{res: 8'hA5, cf: 1'b1, of: 1'b0, we: 1'b0};
      check("R3 zero count", e);
      apply(2'(op), 8'h3C, 8'd0, 1'b0, 1'b1);
      e = '{res: 8'h3C, cf: 1'b0, of: 1'b1, we: 1'b0};
      check("R10 flags pass", e);
    end
  endtask

  task automatic t_mask_to_zero;
    exp_t e;
    apply(2'b00, 8'h96, 8'd8, 1'b1, 1'b1);
    e = '{res: 8'h96, cf: 1'b0, of: 1'b1, we: 1'b1};
    check("R4 rol cnt8", e);
    apply(2'b01, 8'h96, 8'd16, 1'b0, 1'b0);
    e = '{res: 8'h96, cf: 1'b1, of: 1'b1, we: 1'b1};
    check("R4 ror cnt16", e);
  endtask

  task automatic t_ring_zero;
    exp_t e;
    apply(2'b10, 8'h5A, 8'd9, 1'b1, 1'b0);
    e = '{res: 8'h5A, cf: 1'b1, of: 1'b1, we: 1'b1};
    check("R9 rcl cnt9", e);
    apply(2'b11, 8'hC3, 8'd18, 1'b0, 1'b0);
    e = '{res: 8'hC3, cf: 1'b0, of: 1'b1, we: 1'b1};
    check("R9 rcr cnt18", e);
    apply(2'b11, 8'h40, 8'd0, 1'b1, 1'b0);
    e = '{res: 8'h40, cf: 1'b1, of: 1'b1, we: 1'b1};
    check("R8 rcr cnt0", e);
  endtask

  task automatic t_sweep(input logic [1:0] op, input logic [W-1:0] d,
                         input logic cfi, input logic ofi, input string tag);
    for (int c = 0; c < 256; c++) begin
      apply(op, d, 8'(c), cfi, ofi);
      check(tag, model(op, d, 8'(c), cfi, ofi));
    end
  endtask

  initial begin
    op_sel = '0; operand = '0; count = '0; cf_in = 1'b0; of_in = 1'b0;
    t_idle_state();
    t_known_vectors();
    t_raw_zero();
    t_mask_to_zero();
    t_ring_zero();
    t_sweep(2'b00, 8'hB4, 1'b0, 1'b1, "R1 R5 rol sweep");
    t_sweep(2'b01, 8'hB4, 1'b1, 1'b0, "R1 R6 ror sweep");
    t_sweep(2'b10, 8'hB4, 1'b1, 1'b1, "R2 R7 rcl sweep");
    t_sweep(2'b11, 8'hB4, 1'b0, 1'b0, "R2 R8 rcr sweep");
    t_sweep(2'b00, 8'h01, 1'b1, 1'b0, "R1 rol sweep b");
    t_sweep(2'b01, 8'h7F, 1'b0, 1'b1, "R1 ror sweep b");
    t_sweep(2'b10, 8'h01, 1'b0, 1'b0, "R2 rcl sweep b");
    t_sweep(2'b11, 8'hFE, 1'b1, 1'b1, "R2 rcr sweep b");
    done = 1;
  end

  initial begin
    for (int i = 0; i < 50000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout, exp completion");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule